// File: doc/BRIEF.md
# Receive Descriptor Ring Admission Control

This block keeps one receive descriptor ring per DMA channel in a shared descriptor memory and decides, for every arriving cell, whether the cell gets a descriptor. An arrival names its channel and carries a cell-loss-priority bit. The block answers one cycle later with one of three outcomes. The cell is accepted and gets the word address of the descriptor it will fill. It is dropped because the ring is crossing its loss-priority threshold and the cell has CLP=1. Or it is dropped because the ring is full. The host gives descriptors back in ring order through a return port. Each return hands one descriptor back to the engine and lowers that channel's occupancy.

A single configuration load sets four values: the global base word address, the ring length, the loss-priority threshold and the number of channels in use. Each value is clamped to a legal range. The load also clears all ring state. Every channel keeps its own allocate and release positions, its occupancy, two drop counters (loss-priority drops and full-ring drops) and a sticky overflow flag. A channel-select port reads the occupancy and counters back.

Top module: `rx_ring_admit`

## Requirements
- R1: After reset the ring length is 48, the threshold is 38, the base is 0 and all channels are enabled. No response is valid, all overflow flags are clear and every occupancy is 0.
- R2: An arrival sampled at clock edge N is answered with `rsp_valid` after edge N. At most one of accept, loss-priority drop and full drop is set.
- R3: An accepted descriptor's address is base + channel × length × W + position × W, where W = DESC_WORDS (default 2) and position is the channel's allocate position.
- R4: A CLP=1 cell is dropped as a loss-priority drop when the occupancy is strictly greater than the threshold. A CLP=0 cell is accepted whenever the occupancy is below the ring length.
- R5: When the occupancy equals the ring length, any cell is dropped as a full drop, whatever its CLP bit. The channel's overflow flag is then set and stays set until reset or the next configuration load.
- R6: A channel's allocate position and release position each return to 0 after reaching length − 1.
- R7: A return on a channel with nonzero occupancy lowers the occupancy by one. A return on an empty channel has no effect. When an arrival and a return occur in the same cycle, admission uses the occupancy from before the return.
- R8: An accepted descriptor becomes host-owned and is not handed out again until the host returns it. A returned descriptor becomes engine-owned again.
- R9: A configuration load clamps the length to [2, RING_MAX] and the threshold to [0, clamped length]. It clamps the channel count to [1, NUM_CH]. It clears positions, occupancies, counters and overflow flags. An arrival in the load cycle is neither accepted nor dropped.
- R10: `ch_en_mask` has its low (channel count) bits set. An arrival on a disabled channel returns `rsp_valid` with no outcome flag and changes no counter.
- R11: Loss-priority drops and full drops are counted per channel in separate saturating counters. `stat_ch` selects a channel, and its occupancy and counters appear one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load configuration and clear ring state |
| cfg_base | input | ADDR_W | Global descriptor base word address |
| cfg_len | input | LEN_W | Requested ring length |
| cfg_thr | input | LEN_W | Requested CLP=1 occupancy threshold |
| cfg_nch | input | NCH_W | Requested number of channels in use |
| arr_valid | input | 1 | Cell arrival strobe |
| arr_ch | input | CH_W | Arrival channel |
| arr_clp | input | 1 | Arrival cell loss priority |
| ret_valid | input | 1 | Host descriptor return strobe |
| ret_ch | input | CH_W | Return channel |
| rsp_valid | output | 1 | Response for the previous cycle's arrival |
| rsp_accept | output | 1 | Cell accepted |
| rsp_drop_clp1 | output | 1 | Dropped by the threshold rule |
| rsp_drop_full | output | 1 | Dropped because the ring was full |
| rsp_addr | output | ADDR_W | Word address of the granted descriptor |
| ch_en_mask | output | NUM_CH | Enabled channels |
| ovf_flags | output | NUM_CH | Sticky ring-full flags |
| stat_ch | input | CH_W | Channel selected for readback |
| stat_occ | output | LEN_W | Occupancy of the selected channel |
| stat_clp1_drops | output | CNT_W | Loss-priority drop count |
| stat_full_drops | output | CNT_W | Full-ring drop count |

## Verification
The admission rule is driven with runs of CLP=0 and CLP=1 cells around the threshold. One cell lands at occupancy equal to the threshold, which must be accepted, and the next lands one above it, which must be dropped. This separates a strict comparison from an inclusive one. The ring is then filled with CLP=0 cells until a full drop occurs, which separates the full rule from the threshold rule. A CLP=1 cell sent into the full ring shows that a full drop is not miscounted as a loss-priority drop. Address sequences across the ring end show the wrap and the per-channel base offsets. An arrival and a return in the same cycle on a full ring shows which occupancy is used for admission. Clamping is tested with a length below 2, a length above the maximum, a threshold above the length and a channel count of 0.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {
    VRD_NONE = 2'd0,
    VRD_TAKE = 2'd1,
    VRD_CLP1 = 2'd2,
    VRD_FULL = 2'd3
  } verdict_e;
endpackage

// File: rtl/rxr_cfg.sv
module rxr_cfg #(
  parameter int NUM_CH     = 4,
  parameter int RING_MAX   = 64,
  parameter int DEF_LEN    = 48,
  parameter int DEF_THR    = 38,
  parameter int DESC_WORDS = 2,
  parameter int ADDR_W     = 28,
  parameter int LEN_W      = $clog2(RING_MAX + 1),
  parameter int NCH_W      = $clog2(NUM_CH + 1)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load,
  input  logic [ADDR_W-1:0]              in_base,
  input  logic [LEN_W-1:0]               in_len,
  input  logic [LEN_W-1:0]               in_thr,
  input  logic [NCH_W-1:0]               in_nch,
  output logic [LEN_W-1:0]               len_q,
  output logic [LEN_W-1:0]               thr_q,
  output logic [NUM_CH-1:0]              mask_q,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  ch_base_q
);
  logic [LEN_W-1:0]  len_c, thr_c;
  logic [NCH_W-1:0]  nch_c;
  logic [NUM_CH-1:0] mask_c;

  always_comb begin
    if (in_len < LEN_W'(2))                 len_c = LEN_W'(2);
    else if (in_len > LEN_W'(RING_MAX))     len_c = LEN_W'(RING_MAX);
    else                                    len_c = in_len;
    thr_c = (in_thr > len_c) ? len_c : in_thr;
    if (in_nch == '0)                       nch_c = NCH_W'(1);
    else if (in_nch > NCH_W'(NUM_CH))       nch_c = NCH_W'(NUM_CH);
    else                                    nch_c = in_nch;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_mask
    assign mask_c[i] = (NCH_W'(i) < nch_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= LEN_W'(DEF_LEN);
      thr_q  <= LEN_W'(DEF_THR);
      mask_q <= '1;
      for (int i = 0; i < NUM_CH; i++)
        ch_base_q[i] <= ADDR_W'(i * DEF_LEN * DESC_WORDS);
    end else if (load) begin
      len_q  <= len_c;
      thr_q  <= thr_c;
      mask_q <= mask_c;
      for (int i = 0; i < NUM_CH; i++)
        ch_base_q[i] <= in_base + ADDR_W'(i) * ADDR_W'(len_c) * ADDR_W'(DESC_WORDS);
    end
  end

  assert_cfg_range_R9: assert property (@(posedge clk) disable iff (rst)
    (thr_q <= len_q) && (len_q >= LEN_W'(2)) && (len_q <= LEN_W'(RING_MAX)) && mask_q[0]);
endmodule

// File: rtl/rxr_chan.sv
module rxr_chan
  import rxr_pkg::*;
#(
  parameter int LEN_W = 7,
  parameter int POS_W = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             arr,
  input  logic             clp,
  input  logic             ret,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] thr,
  output verdict_e         vrd,
  output logic [POS_W-1:0] alloc_pos,
  output logic [POS_W-1:0] rel_pos,
  output logic [LEN_W-1:0] occ,
  output logic [CNT_W-1:0] clp1_cnt,
  output logic [CNT_W-1:0] full_cnt,
  output logic             ovf
);
  logic ring_full, above_thr, take, give, last_alloc, last_rel;

  assign ring_full  = (occ >= len);
  assign above_thr  = (occ > thr);
  assign last_alloc = (LEN_W'(alloc_pos) + LEN_W'(1) == len);
  assign last_rel   = (LEN_W'(rel_pos) + LEN_W'(1) == len);

  always_comb begin
    if (!arr)                  vrd = VRD_NONE;
    else if (ring_full)        vrd = VRD_FULL;
    else if (clp && above_thr) vrd = VRD_CLP1;
    else                       vrd = VRD_TAKE;
  end

  assign take = (vrd == VRD_TAKE);
  assign give = ret && (occ != '0);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      alloc_pos <= '0;
      rel_pos   <= '0;
      occ       <= '0;
      clp1_cnt  <= '0;
      full_cnt  <= '0;
      ovf       <= 1'b0;
    end else begin
      if (take) alloc_pos <= last_alloc ? '0 : alloc_pos + POS_W'(1);
      if (give) rel_pos   <= last_rel   ? '0 : rel_pos + POS_W'(1);
      occ <= occ + LEN_W'(take) - LEN_W'(give);
      if (vrd == VRD_CLP1 && clp1_cnt != '1) clp1_cnt <= clp1_cnt + CNT_W'(1);
      if (vrd == VRD_FULL && full_cnt != '1) full_cnt <= full_cnt + CNT_W'(1);
      if (vrd == VRD_FULL) ovf <= 1'b1;
    end
  end

  assert_occ_bound_R4: assert property (@(posedge clk) disable iff (rst)
    occ <= len);
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clear) |=> ovf);
  assert_pos_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (LEN_W'(alloc_pos) < len) && (LEN_W'(rel_pos) < len));
endmodule

// File: rtl/rxr_own.sv
module rxr_own #(
  parameter int NUM_CH   = 4,
  parameter int RING_MAX = 64,
  parameter int CH_W     = 2,
  parameter int POS_W    = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clear,
  input  logic                          set_en,
  input  logic [CH_W-1:0]               set_ch,
  input  logic [POS_W-1:0]              set_pos,
  input  logic                          clr_en,
  input  logic [CH_W-1:0]               clr_ch,
  input  logic [POS_W-1:0]              clr_pos,
  input  logic [NUM_CH-1:0][POS_W-1:0]  rd_pos,
  output logic [NUM_CH-1:0]             rd_host
);
  localparam int DEPTH = NUM_CH * RING_MAX;
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0] host_q;
  logic [IDX_W-1:0] set_idx, clr_idx;

  assign set_idx = IDX_W'(set_ch) * IDX_W'(RING_MAX) + IDX_W'(set_pos);
  assign clr_idx = IDX_W'(clr_ch) * IDX_W'(RING_MAX) + IDX_W'(clr_pos);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      host_q <= '0;
    end else begin
      if (set_en) host_q[set_idx] <= 1'b1;
      if (clr_en) host_q[clr_idx] <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_rd
    assign rd_host[i] = host_q[IDX_W'(i) * IDX_W'(RING_MAX) + IDX_W'(rd_pos[i])];
  end

  assert_return_owned_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !clear) |-> host_q[clr_idx]);
endmodule

// File: rtl/rx_ring_admit.sv
module rx_ring_admit
  import rxr_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int RING_MAX   = 64,
  parameter int DEF_LEN    = 48,
  parameter int DEF_THR    = 38,
  parameter int DESC_WORDS = 2,
  parameter int ADDR_W     = 28,
  parameter int CNT_W      = 16,
  parameter int LEN_W      = $clog2(RING_MAX + 1),
  parameter int POS_W      = $clog2(RING_MAX),
  parameter int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int NCH_W      = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [LEN_W-1:0]  cfg_thr,
  input  logic [NCH_W-1:0]  cfg_nch,
  input  logic              arr_valid,
  input  logic [CH_W-1:0]   arr_ch,
  input  logic              arr_clp,
  input  logic              ret_valid,
  input  logic [CH_W-1:0]   ret_ch,
  output logic              rsp_valid,
  output logic              rsp_accept,
  output logic              rsp_drop_clp1,
  output logic              rsp_drop_full,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [NUM_CH-1:0] ch_en_mask,
  output logic [NUM_CH-1:0] ovf_flags,
  input  logic [CH_W-1:0]   stat_ch,
  output logic [LEN_W-1:0]  stat_occ,
  output logic [CNT_W-1:0]  stat_clp1_drops,
  output logic [CNT_W-1:0]  stat_full_drops
);
  logic [LEN_W-1:0]               len_q, thr_q;
  logic [NUM_CH-1:0][ADDR_W-1:0]  ch_base;
  logic [NUM_CH-1:0][POS_W-1:0]   alloc_a;
  logic [POS_W-1:0]               rel_a   [NUM_CH];
  logic [LEN_W-1:0]               occ_a   [NUM_CH];
  logic [CNT_W-1:0]               c1_a    [NUM_CH];
  logic [CNT_W-1:0]               cf_a    [NUM_CH];
  verdict_e                       vrd_a   [NUM_CH];
  logic [NUM_CH-1:0]              host_at_alloc;
  logic                           arr_ok, ret_ok, take, give;
  verdict_e                       cur_vrd;

  rxr_cfg #(
    .NUM_CH(NUM_CH), .RING_MAX(RING_MAX), .DEF_LEN(DEF_LEN), .DEF_THR(DEF_THR),
    .DESC_WORDS(DESC_WORDS), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NCH_W(NCH_W)
  ) cfg_i (
    .clk(clk), .rst(rst), .load(cfg_load),
    .in_base(cfg_base), .in_len(cfg_len), .in_thr(cfg_thr), .in_nch(cfg_nch),
    .len_q(len_q), .thr_q(thr_q), .mask_q(ch_en_mask), .ch_base_q(ch_base)
  );

  assign arr_ok  = arr_valid && !cfg_load && ch_en_mask[arr_ch];
  assign ret_ok  = ret_valid && !cfg_load && ch_en_mask[ret_ch];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    rxr_chan #(.LEN_W(LEN_W), .POS_W(POS_W), .CNT_W(CNT_W)) chan_i (
      .clk(clk), .rst(rst), .clear(cfg_load),
      .arr(arr_ok && (arr_ch == CH_W'(i))), .clp(arr_clp),
      .ret(ret_ok && (ret_ch == CH_W'(i))),
      .len(len_q), .thr(thr_q),
      .vrd(vrd_a[i]), .alloc_pos(alloc_a[i]), .rel_pos(rel_a[i]), .occ(occ_a[i]),
      .clp1_cnt(c1_a[i]), .full_cnt(cf_a[i]), .ovf(ovf_flags[i])
    );
  end

  assign cur_vrd = vrd_a[arr_ch];
  assign take    = arr_ok && (cur_vrd == VRD_TAKE);
  assign give    = ret_ok && (occ_a[ret_ch] != '0);

  rxr_own #(.NUM_CH(NUM_CH), .RING_MAX(RING_MAX), .CH_W(CH_W), .POS_W(POS_W)) own_i (
    .clk(clk), .rst(rst), .clear(cfg_load),
    .set_en(take), .set_ch(arr_ch), .set_pos(alloc_a[arr_ch]),
    .clr_en(give), .clr_ch(ret_ch), .clr_pos(rel_a[ret_ch]),
    .rd_pos(alloc_a), .rd_host(host_at_alloc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_accept    <= 1'b0;
      rsp_drop_clp1 <= 1'b0;
      rsp_drop_full <= 1'b0;
      rsp_addr      <= '0;
    end else begin
      rsp_valid     <= arr_valid;
      rsp_accept    <= take;
      rsp_drop_clp1 <= arr_ok && (cur_vrd == VRD_CLP1);
      rsp_drop_full <= arr_ok && (cur_vrd == VRD_FULL);
      rsp_addr      <= take ? ch_base[arr_ch] + ADDR_W'(alloc_a[arr_ch]) * ADDR_W'(DESC_WORDS)
                            : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_occ        <= '0;
      stat_clp1_drops <= '0;
      stat_full_drops <= '0;
    end else begin
      stat_occ        <= occ_a[stat_ch];
      stat_clp1_drops <= c1_a[stat_ch];
      stat_full_drops <= cf_a[stat_ch];
    end
  end

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_accept, rsp_drop_clp1, rsp_drop_full}));
  assert_outcome_needs_arrival_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_accept || rsp_drop_clp1 || rsp_drop_full) |-> rsp_valid);
  assert_fill_engine_owned_R8: assert property (@(posedge clk) disable iff (rst)
    take |-> !host_at_alloc[arr_ch]);
endmodule

// File: tb/rx_ring_admit_tb_top.sv
`timescale 1ns/1ps
module rx_ring_admit_tb_top;
  localparam int AW = 28;

  logic clk = 1'b0;
  logic rst;
  logic cfg_load;
  logic [AW-1:0] cfg_base;
  logic [6:0] cfg_len, cfg_thr;
  logic [2:0] cfg_nch;
  logic arr_valid, arr_clp, ret_valid;
  logic [1:0] arr_ch, ret_ch, stat_ch;
  logic rsp_valid, rsp_accept, rsp_drop_clp1, rsp_drop_full;
  logic [AW-1:0] rsp_addr;
  logic [3:0] ch_en_mask, ovf_flags;
  logic [6:0] stat_occ;
  logic [15:0] stat_clp1_drops, stat_full_drops;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  logic rv, ra, rc, rf;
  logic [AW-1:0] radr;
  logic [6:0] s_occ;
  logic [15:0] s_c1, s_cf;

  always #2 clk = ~clk;

  rx_ring_admit dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_base(cfg_base), .cfg_len(cfg_len),
    .cfg_thr(cfg_thr), .cfg_nch(cfg_nch), .arr_valid(arr_valid), .arr_ch(arr_ch),
    .arr_clp(arr_clp), .ret_valid(ret_valid), .ret_ch(ret_ch), .rsp_valid(rsp_valid),
    .rsp_accept(rsp_accept), .rsp_drop_clp1(rsp_drop_clp1), .rsp_drop_full(rsp_drop_full),
    .rsp_addr(rsp_addr), .ch_en_mask(ch_en_mask), .ovf_flags(ovf_flags), .stat_ch(stat_ch),
    .stat_occ(stat_occ), .stat_clp1_drops(stat_clp1_drops), .stat_full_drops(stat_full_drops)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic arrive(input int ch, input bit clp);
    @(negedge clk);
    arr_valid = 1'b1; arr_ch = ch[1:0]; arr_clp = clp;
    @(negedge clk);
    arr_valid = 1'b0;
    rv = rsp_valid; ra = rsp_accept; rc = rsp_drop_clp1; rf = rsp_drop_full; radr = rsp_addr;
  endtask

  task automatic give_back(input int ch);
    @(negedge clk);
    ret_valid = 1'b1; ret_ch = ch[1:0];
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic arrive_and_return(input int ch, input bit clp);
    @(negedge clk);
    arr_valid = 1'b1; arr_ch = ch[1:0]; arr_clp = clp;
    ret_valid = 1'b1; ret_ch = ch[1:0];
    @(negedge clk);
    arr_valid = 1'b0; ret_valid = 1'b0;
    rv = rsp_valid; ra = rsp_accept; rc = rsp_drop_clp1; rf = rsp_drop_full; radr = rsp_addr;
  endtask

  task automatic read_stat(input int ch);
    @(negedge clk);
    stat_ch = ch[1:0];
    @(negedge clk);
    s_occ = stat_occ; s_c1 = stat_clp1_drops; s_cf = stat_full_drops;
  endtask

  task automatic load_cfg(input int base, input int len, input int thr, input int nch);
    @(negedge clk);
    cfg_load = 1'b1; cfg_base = AW'(base); cfg_len = 7'(len); cfg_thr = 7'(thr); cfg_nch = 3'(nch);
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "enable mask", ch_en_mask, 4'hF);
    chk("R1", "overflow flags", ovf_flags, 0);
    read_stat(0);
    chk("R1", "occupancy", s_occ, 0);
  endtask

  task automatic t_default_layout;
    arrive(1, 1'b0);
    chk("R2", "valid", rv, 1);
    chk("R2", "accept", ra, 1);
    chk("R3", "ch1 first addr", radr, 96);
    arrive(1, 1'b1);
    chk("R3", "ch1 second addr", radr, 98);
  endtask

  task automatic t_default_threshold;
    int bad = 0;
    for (int k = 0; k < 38; k++) begin
      arrive(2, 1'b0);
      if (!ra) bad++;
    end
    chk("R1", "38 clp0 accepted", bad, 0);
    arrive(2, 1'b1);
    chk("R1", "clp1 at occ 38 accepted", ra, 1);
    arrive(2, 1'b1);
    chk("R1", "clp1 at occ 39 dropped", rc, 1);
    bad = 0;
    for (int k = 0; k < 9; k++) begin
      arrive(2, 1'b0);
      if (!ra) bad++;
    end
    chk("R1", "fill to 48", bad, 0);
    arrive(2, 1'b0);
    chk("R5", "full at 48", rf, 1);
    chk("R5", "ovf ch2", ovf_flags[2], 1);
  endtask

  task automatic t_config;
    load_cfg(32'h1000, 4, 2, 3);
    chk("R10", "mask for 3 channels", ch_en_mask, 4'b0111);
    chk("R9", "ovf cleared", ovf_flags, 0);
    read_stat(2);
    chk("R9", "occ cleared", s_occ, 0);
    chk("R9", "clp1 count cleared", s_c1, 0);
    arrive(2, 1'b0);
    chk("R3", "ch2 base addr", radr, 32'h1010);
  endtask

  task automatic t_threshold_and_full;
    arrive(0, 1'b0); chk("R3", "slot0", radr, 32'h1000);
    arrive(0, 1'b0); chk("R3", "slot1", radr, 32'h1002);
    arrive(0, 1'b1);
    chk("R4", "clp1 at occ==thr accepted", ra, 1);
    chk("R3", "slot2", radr, 32'h1004);
    arrive(0, 1'b1);
    chk("R4", "clp1 above thr dropped", rc, 1);
    chk("R4", "clp1 drop not accept", ra, 0);
    arrive(0, 1'b0);
    chk("R4", "clp0 above thr accepted", ra, 1);
    chk("R3", "slot3", radr, 32'h1006);
    arrive(0, 1'b0);
    chk("R5", "clp0 full drop", rf, 1);
    arrive(0, 1'b1);
    chk("R5", "clp1 full drop", rf, 1);
    chk("R5", "clp1 into full not clp1 drop", rc, 0);
    chk("R5", "ovf ch0", ovf_flags[0], 1);
    read_stat(0);
    chk("R11", "clp1 drops", s_c1, 1);
    chk("R11", "full drops", s_cf, 2);
    chk("R4", "occ full", s_occ, 4);
  endtask

  task automatic t_same_cycle;
    arrive_and_return(0, 1'b0);
    chk("R7", "pre-return occupancy used", rf, 1);
    read_stat(0);
    chk("R7", "occ after return", s_occ, 3);
    chk("R11", "full drops", s_cf, 3);
    arrive(0, 1'b0);
    chk("R6", "alloc wrapped", ra, 1);
    chk("R8", "returned slot reused", radr, 32'h1000);
  endtask

  task automatic t_returns;
    for (int k = 0; k < 4; k++) give_back(0);
    read_stat(0);
    chk("R7", "drained", s_occ, 0);
    give_back(0);
    read_stat(0);
    chk("R7", "return on empty ignored", s_occ, 0);
    arrive(0, 1'b0);
    chk("R6", "release wrap keeps order", radr, 32'h1002);
    chk("R5", "ovf sticky", ovf_flags[0], 1);
  endtask

  task automatic t_disabled;
    arrive(3, 1'b0);
    chk("R10", "disabled valid", rv, 1);
    chk("R10", "disabled no flags", {ra, rc, rf}, 0);
    read_stat(3);
    chk("R10", "disabled counters", s_cf + s_c1, 0);
  endtask

  task automatic t_clamp_low;
    load_cfg(0, 1, 9, 0);
    chk("R9", "nch 0 -> 1", ch_en_mask, 4'b0001);
    arrive(0, 1'b1); chk("R9", "len2 slot0", ra, 1);
    arrive(0, 1'b1);
    chk("R9", "thr clamped, clp1 accepted", ra, 1);
    chk("R9", "len2 slot1 addr", radr, 2);
    arrive(0, 1'b1);
    chk("R9", "len clamped to 2 full", rf, 1);
    arrive(1, 1'b0);
    chk("R10", "ch1 disabled", ra, 0);
  endtask

  task automatic t_clamp_high;
    load_cfg(0, 100, 0, 7);
    chk("R9", "nch clamped 4", ch_en_mask, 4'hF);
    arrive(3, 1'b1);
    chk("R9", "len clamped 64 base", radr, 384);
    chk("R4", "clp1 at occ0 thr0 accepted", ra, 1);
    arrive(3, 1'b1);
    chk("R4", "clp1 at occ1 thr0 dropped", rc, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_load = 1'b0; cfg_base = '0; cfg_len = '0; cfg_thr = '0; cfg_nch = '0;
    arr_valid = 1'b0; arr_ch = '0; arr_clp = 1'b0; ret_valid = 1'b0; ret_ch = '0; stat_ch = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_default_layout();
    t_default_threshold();
    t_config();
    t_threshold_and_full();
    t_same_cycle();
    t_returns();
    t_disabled();
    t_clamp_low();
    t_clamp_high();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule